// File: doc/BRIEF.md
# Framed 24-bit Serial Command Receiver

This block receives commands over a three-wire serial link (active-low select, serial clock, data in). It is the front end of a converter control path. The three pins are brought into the system clock domain through a synchroniser. The block then looks for falling edges of the serial clock and shifts in the data most significant bit first. Each select window carries one 24-bit frame. The first eight bits form a control byte and the next sixteen form a data word.

When the 24th falling edge arrives, the block does three things. It publishes the control byte and data word together. It raises a valid strobe for one system clock cycle. If handover is enabled, it pulls its chain output low. That output can drive the select of the next device in a daisy chain, which then reads the bits that follow. Bits beyond the 24th do not affect this device. A window that closes before 24 bits is discarded. The chain output returns high once the select is released.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, `frame_valid` is 0, `ctrl` and `data` are all zeros, and `next_sel_n` is 1.
- R2: Bits are taken on serial clock falling edges while `cs_n` is low, most significant first. The first 8 bits captured form `ctrl` (first bit at `ctrl[7]`). The next 16 form `data` (first of them at `data[15]`).
- R3: Each complete frame produces exactly one `frame_valid` pulse, one system cycle wide. `ctrl` and `data` carry the new frame from that cycle onward.
- R4: If `cs_n` rises before the 24th falling edge, no pulse is produced and `ctrl`/`data` keep their previous values.
- R5: Falling edges after the 24th in the same window are ignored. They produce no further pulse and do not change `ctrl` or `data`.
- R6: With `ready_en` high, `next_sel_n` goes low after the 24th falling edge. It stays low while `cs_n` stays low, and it returns to 1 after `cs_n` rises.
- R7: With `ready_en` low, `next_sel_n` stays at 1 for the whole frame.
- R8: Frames are received correctly whether the serial clock idles high or low between windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Asynchronous active-low frame select |
| sclk | input | 1 | Asynchronous serial clock; data taken on falling edges |
| sdi | input | 1 | Asynchronous serial data |
| ready_en | input | 1 | Enables the chain handover output |
| frame_valid | output | 1 | One-cycle strobe for a complete frame |
| ctrl | output | 8 | Control byte of the last complete frame |
| data | output | 16 | Data word of the last complete frame |
| next_sel_n | output | 1 | Chain output, low to select the next device |

## Verification
A bit counter that is off by one, or that fails to clear when the select rises, shows up at the ports on the very next frame. The data lands shifted by one bit, the strobe fires early or on a partial frame, or it never fires. A stale chain output shows as `next_sel_n` still low a few system cycles after the select rises. A counter that does not stop at 24 shows as a second strobe or changed data while the extra bits of an overlong window are being clocked. The scenarios therefore place every check a few system cycles after the relevant serial edge. That delay covers the synchroniser depth plus the output register.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
    localparam int CTRL_W  = 8;
    localparam int DATA_W  = 16;
    localparam int FRAME_W = CTRL_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic sdi;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, sdi: 1'b0};

    function automatic frame_t split_frame(input logic [FRAME_W-1:0] word);
        return frame_t'(word);
    endfunction
endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[s] <= RST_VAL;
            else if (s == 0)
                chain[s] <= d;
            else
                chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sercmd_shift.sv
module sercmd_shift
    import sercmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_active,
    input  logic               sclk_fall,
    input  logic               sdi,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic               frame_done,
    output logic [FRAME_W-1:0] frame_word
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] shreg;
    logic               take;

    assign take = cs_active && sclk_fall && (bit_cnt != FULL);

    always_ff @(posedge clk) begin
        if (rst || !cs_active) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (take) begin
            shreg   <= {shreg[FRAME_W-2:0], sdi};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign frame_done = take && (bit_cnt == LAST);
    assign frame_word = {shreg[FRAME_W-2:0], sdi};
endmodule

// File: rtl/sercmd_out.sv
module sercmd_out
    import sercmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_done,
    input  logic [FRAME_W-1:0] frame_word,
    input  logic               cs_active,
    input  logic               ready_en,
    output logic               frame_valid,
    output logic [CTRL_W-1:0]  ctrl,
    output logic [DATA_W-1:0]  data,
    output logic               next_sel_n
);
    frame_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held        <= '0;
            frame_valid <= 1'b0;
            next_sel_n  <= 1'b1;
        end else begin
            frame_valid <= frame_done;
            if (frame_done)
                held <= split_frame(frame_word);
            if (!cs_active)
                next_sel_n <= 1'b1;
            else if (frame_done && ready_en)
                next_sel_n <= 1'b0;
        end
    end

    assign ctrl = held.ctrl;
    assign data = held.data;
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
    import sercmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              ready_en,
    output logic              frame_valid,
    output logic [CTRL_W-1:0] ctrl,
    output logic [DATA_W-1:0] data,
    output logic              next_sel_n
);
    pins_t              raw_pins;
    pins_t              sync_pins;
    logic               sclk_prev;
    logic               sclk_fall;
    logic               cs_active;
    logic [CNT_W-1:0]   bit_cnt;
    logic               frame_done;
    logic [FRAME_W-1:0] frame_word;

    assign raw_pins = '{cs_n: cs_n, sclk: sclk, sdi: sdi};

    sercmd_sync #(
        .WIDTH   ($bits(pins_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (sync_pins)
    );

    always_ff @(posedge clk) begin
        if (rst)
            sclk_prev <= 1'b0;
        else
            sclk_prev <= sync_pins.sclk;
    end

    assign sclk_fall = sclk_prev && !sync_pins.sclk;
    assign cs_active = !sync_pins.cs_n;

    sercmd_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .cs_active  (cs_active),
        .sclk_fall  (sclk_fall),
        .sdi        (sync_pins.sdi),
        .bit_cnt    (bit_cnt),
        .frame_done (frame_done),
        .frame_word (frame_word)
    );

    sercmd_out u_out (
        .clk         (clk),
        .rst         (rst),
        .frame_done  (frame_done),
        .frame_word  (frame_word),
        .cs_active   (cs_active),
        .ready_en    (ready_en),
        .frame_valid (frame_valid),
        .ctrl        (ctrl),
        .data        (data),
        .next_sel_n  (next_sel_n)
    );
endmodule

// File: rtl/sercmd_chk.sv
module sercmd_chk
    import sercmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_active,
    input logic              frame_done,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              ready_en,
    input logic              frame_valid,
    input logic [CTRL_W-1:0] ctrl,
    input logic [DATA_W-1:0] data,
    input logic              next_sel_n
);
    p_pulse_width_r3: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    p_done_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> frame_valid);

    p_hold_outputs_r4: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> ($stable(ctrl) && $stable(data)));

    p_cnt_saturate_r5: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(FRAME_W));

    p_release_ready_r6: assert property (@(posedge clk) disable iff (rst)
        !cs_active |=> next_sel_n);

    p_ready_gated_r7: assert property (@(posedge clk) disable iff (rst)
        (next_sel_n && !ready_en) |=> next_sel_n);
endmodule

bind serial_cmd_rx sercmd_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_active   (cs_active),
    .frame_done  (frame_done),
    .bit_cnt     (bit_cnt),
    .ready_en    (ready_en),
    .frame_valid (frame_valid),
    .ctrl        (ctrl),
    .data        (data),
    .next_sel_n  (next_sel_n)
);

// File: tb/sim_serial_cmd_rx.sv
module sim_serial_cmd_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        ready_en = 1'b1;
    logic        frame_valid;
    logic [7:0]  ctrl;
    logic [15:0] data;
    logic        next_sel_n;

    int tests = 0;
    int fails = 0;
    int pulses = 0;
    bit finished = 1'b0;

    localparam int H = 3;

    always #2.5 clk = ~clk;

    serial_cmd_rx u0 (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .sdi         (sdi),
        .ready_en    (ready_en),
        .frame_valid (frame_valid),
        .ctrl        (ctrl),
        .data        (data),
        .next_sel_n  (next_sel_n)
    );

    always @(posedge clk) if (!rst && frame_valid) pulses <= pulses + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sends n bits MSB-first from the top of word, leaves cs_n low
    task automatic clock_bits(input logic [39:0] word, input int n, input bit idle_hi);
        sclk = idle_hi;
        wait_cyc(H);
        cs_n = 1'b0;
        wait_cyc(H);
        for (int i = 0; i < n; i++) begin
            if (idle_hi) begin
                sdi = word[39-i];
                wait_cyc(H);
                sclk = 1'b0;
                wait_cyc(H);
                sclk = 1'b1;
                wait_cyc(H);
            end else begin
                sclk = 1'b1;
                sdi = word[39-i];
                wait_cyc(H);
                sclk = 1'b0;
                wait_cyc(H);
            end
        end
        wait_cyc(8);
    endtask

    task automatic close_window();
        cs_n = 1'b1;
        wait_cyc(8);
    endtask

    task automatic t_reset();
        check(frame_valid == 1'b0, "R1 valid", 32'(frame_valid), 0);
        check(ctrl == 8'h00 && data == 16'h0000, "R1 outputs", {8'h0, ctrl, data}, 0);
        check(next_sel_n == 1'b1, "R1 chain out", 32'(next_sel_n), 1);
    endtask

    task automatic t_frame(input logic [23:0] fr, input bit idle_hi, input bit en,
                           input string req);
        int p0 = pulses;
        ready_en = en;
        clock_bits({fr, 16'h0}, 24, idle_hi);
        check(pulses - p0 == 1, {req, " one pulse R3"}, 32'(pulses - p0), 1);
        check(ctrl == fr[23:16], {req, " ctrl R2"}, 32'(ctrl), 32'(fr[23:16]));
        check(data == fr[15:0], {req, " data R2"}, 32'(data), 32'(fr[15:0]));
        if (en) check(next_sel_n == 1'b0, {req, " chain low R6"}, 32'(next_sel_n), 0);
        else    check(next_sel_n == 1'b1, {req, " chain off R7"}, 32'(next_sel_n), 1);
        close_window();
        check(next_sel_n == 1'b1, {req, " chain released R6"}, 32'(next_sel_n), 1);
    endtask

    task automatic t_partial();
        int p0 = pulses;
        logic [7:0]  c0 = ctrl;
        logic [15:0] d0 = data;
        ready_en = 1'b1;
        clock_bits(40'hFF_FFFF_FFFF, 23, 1'b1);
        check(next_sel_n == 1'b1, "R4 chain stays high", 32'(next_sel_n), 1);
        close_window();
        check(pulses == p0, "R4 no pulse", 32'(pulses - p0), 0);
        check(ctrl == c0 && data == d0, "R4 outputs held", {8'h0, ctrl, data}, {8'h0, c0, d0});
    endtask

    task automatic t_overlong();
        int p0 = pulses;
        ready_en = 1'b1;
        clock_bits(40'h5A_C3_3C_FF_00, 40, 1'b0);
        check(pulses - p0 == 1, "R5 single pulse", 32'(pulses - p0), 1);
        check(ctrl == 8'h5A && data == 16'hC33C, "R5 first 24 kept",
              {8'h0, ctrl, data}, 32'h005AC33C);
        check(next_sel_n == 1'b0, "R5 chain low through extra bits", 32'(next_sel_n), 0);
        close_window();
    endtask

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        t_reset();
        t_frame(24'hA5_1234, 1'b1, 1'b1, "R8 idle high");
        t_frame(24'h3C_FEDC, 1'b0, 1'b1, "R8 idle low");
        t_frame(24'h80_0001, 1'b1, 1'b0, "R7 disabled");
        t_frame(24'h01_8000, 1'b0, 1'b1, "R2 edge bits");
        t_partial();
        t_overlong();
        t_frame(24'hFF_FFFF, 1'b1, 1'b1, "R3 back to back");
        t_frame(24'h00_0000, 1'b1, 1'b1, "R3 zeros");
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule